// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog peripheral on a simple single-clock memory-mapped bus. Software arms it by programming a prescaler select and a 12-bit reload field, then enabling it. From then on it must keep writing a fixed restart word. If it stops, a down-counter clocked by the prescaled tick reaches zero. The block then raises a sticky status flag and signals the timeout. It can emit a single reset pulse of programmable length, or hold an interrupt line high, or do both.

Stray writes must not disturb a running watchdog. For that reason every control write carries an access key in its upper bits, and a write without the right key is dropped. The counter is reloaded only by one exact 32-bit restart word. Clearing the enable bit freezes the count where it stands. Setting the bit again resumes counting from that value.

Bus requests are accepted in any cycle where `req_valid` is high and take effect at that clock edge. Read data is registered and appears one cycle later.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, both timeout outputs are low. The mode register reads 0, the counter-control register reads 0x0000_3FFC (reload all ones, prescaler select 0) and the status register reads 0.
- R2: A write to offset 0x0 updates the mode register only when bits [23:12] equal 0xABC; any other key leaves it unchanged. The stored fields are: bit 0 enable, bit 1 reset-output enable, bit 2 interrupt enable, bits [5:4] pulse-length code. On readback the key bits read as zero.
- R3: A write to offset 0x4 updates the counter-control register only when bits [23:14] equal 0x248. The stored fields are the prescaler select in bits [1:0] and the reload value in bits [13:2]. On readback the key bits read as zero.
- R4: Prescaler select 0, 1, 2 and 3 divides the clock by 8, 64, 512 and 4096. After a restart, the counter holds N = reload·2^L + 2^L − 1, where L is the low-fill width parameter. With the watchdog enabled throughout, the status flag sets at the clock edge N·div cycles after the restart edge.
- R5: Writing exactly 0x0000_1999 to offset 0x8 reloads the counter, clears the status flag and restarts the prescaler. Any other value written there has no effect.
- R6: While the enable bit is clear, the count and the prescaler phase hold. After re-enable, the remaining enabled cycles complete the same N·div total.
- R7: The status register at offset 0xC reports the zero flag in bit 0. The flag stays set until a valid restart.
- R8: When reset output is enabled, a timeout drives `wdt_rst_o` high for exactly 2, 4, 8 or 16 cycles for codes 00, 01, 10 and 11. The pulse starts one cycle after the flag sets and occurs once per timeout.
- R9: `wdt_irq_o` is high exactly while the flag has been set for at least one cycle and interrupt enable is set. It falls one cycle after a valid restart.
- R10: A valid restart accepted on the same edge as the terminal prescaled tick wins: the counter reloads and no flag, pulse or interrupt occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for bus and timer |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte offset of the register |
| req_wdata | input | 32 | Write data including key |
| rsp_rdata | output | 32 | Registered read data, one cycle after the request |
| wdt_rst_o | output | 1 | Timeout reset pulse |
| wdt_irq_o | output | 1 | Timeout interrupt level |

## Verification
The restart write and the terminal prescaled tick can land on the same clock edge. This is the collision that decides whether a late-serviced watchdog fires. The bench computes the terminal edge from the restart edge, the reload value and the divisor. It then issues a second restart that is accepted on exactly that edge. The expected result is that the interrupt stays low and the status stays clear through the following cycle. The interrupt must then rise precisely one full period after the colliding restart, which proves that the reload took priority over the decrement to zero.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam logic [11:0] MODE_KEY      = 12'hABC;
  localparam logic [9:0]  CCTL_KEY      = 10'h248;
  localparam logic [31:0] RESTART_MAGIC = 32'h0000_1999;

  localparam logic [3:0] ADDR_MODE    = 4'h0;
  localparam logic [3:0] ADDR_CCTL    = 4'h4;
  localparam logic [3:0] ADDR_RESTART = 4'h8;
  localparam logic [3:0] ADDR_STATUS  = 4'hC;

  typedef struct packed {
    logic [1:0] len;
    logic       irq_en;
    logic       rst_en;
    logic       en;
  } mode_t;

  // pulse length in clock cycles for a 2-bit code: 2, 4, 8, 16
  function automatic logic [4:0] pulse_cycles(input logic [1:0] code);
    return 5'd2 << code;
  endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int RELOAD_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [3:0]          req_addr,
  input  logic [31:0]         req_wdata,
  input  logic                zero_flag,
  output mode_t               mode,
  output logic [1:0]          pre_sel,
  output logic [RELOAD_W-1:0] reload,
  output logic                restart_hit,
  output logic [31:0]         rsp_rdata
);

  logic wr, rd;
  logic mode_ok, cctl_ok;

  assign wr = req_valid && req_write;
  assign rd = req_valid && !req_write;

  assign mode_ok     = wr && (req_addr == ADDR_MODE) && (req_wdata[23:12] == MODE_KEY);
  assign cctl_ok     = wr && (req_addr == ADDR_CCTL) && (req_wdata[23:14] == CCTL_KEY);
  assign restart_hit = wr && (req_addr == ADDR_RESTART) && (req_wdata == RESTART_MAGIC);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= '0;
      pre_sel <= 2'd0;
      reload  <= '1;
    end else begin
      if (mode_ok) begin
        mode.en     <= req_wdata[0];
        mode.rst_en <= req_wdata[1];
        mode.irq_en <= req_wdata[2];
        mode.len    <= req_wdata[5:4];
      end
      if (cctl_ok) begin
        pre_sel <= req_wdata[1:0];
        reload  <= req_wdata[2 +: RELOAD_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_rdata <= '0;
    end else if (rd) begin
      case (req_addr)
        ADDR_MODE:   rsp_rdata <= {26'd0, mode.len, 1'b0, mode.irq_en, mode.rst_en, mode.en};
        ADDR_CCTL:   rsp_rdata <= 32'({reload, pre_sel});
        ADDR_STATUS: rsp_rdata <= {31'd0, zero_flag};
        default:     rsp_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int RELOAD_W = 12,
  parameter int LOW_W    = 12,
  localparam int CNT_W   = RELOAD_W + LOW_W,
  localparam int PRE_W   = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [1:0]          pre_sel,
  input  logic [RELOAD_W-1:0] reload,
  input  logic                restart,
  output logic [CNT_W-1:0]    cnt,
  output logic                zero_flag,
  output logic                zero_evt
);

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_mask;
  logic             tick;
  int unsigned      shift;

  // divide by 2^(3*(sel+1)): 8, 64, 512, 4096
  always_comb begin
    shift    = 3 * (int'(pre_sel) + 1);
    pre_mask = (PRE_W'(1) << shift) - PRE_W'(1);
    tick     = (pre_cnt & pre_mask) == pre_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt   <= '0;
      cnt       <= '1;
      zero_flag <= 1'b0;
      zero_evt  <= 1'b0;
    end else begin
      zero_evt <= 1'b0;
      if (restart) begin
        pre_cnt   <= '0;
        cnt       <= {reload, {LOW_W{1'b1}}};
        zero_flag <= 1'b0;
      end else if (en) begin
        pre_cnt <= pre_cnt + PRE_W'(1);
        if (tick && cnt != '0) begin
          cnt <= cnt - CNT_W'(1);
          if (cnt == CNT_W'(1)) begin
            zero_flag <= 1'b1;
            zero_evt  <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/wdog_out.sv
module wdog_out
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       zero_flag,
  input  logic       zero_evt,
  input  logic       rst_en,
  input  logic       irq_en,
  input  logic [1:0] len,
  output logic       wdt_rst_o,
  output logic       wdt_irq_o
);

  logic [4:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain    <= '0;
      wdt_rst_o <= 1'b0;
      wdt_irq_o <= 1'b0;
    end else begin
      wdt_irq_o <= zero_flag && irq_en;
      if (zero_evt && rst_en) begin
        remain    <= pulse_cycles(len) - 5'd1;
        wdt_rst_o <= 1'b1;
      end else if (remain != '0) begin
        remain <= remain - 5'd1;
      end else begin
        wdt_rst_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int RELOAD_W = 12,
  parameter int LOW_W    = 12,
  localparam int CNT_W   = RELOAD_W + LOW_W
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [3:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic [31:0] rsp_rdata,
  output logic        wdt_rst_o,
  output logic        wdt_irq_o
);

  mode_t               mode;
  logic [1:0]          pre_sel;
  logic [RELOAD_W-1:0] reload;
  logic                restart_hit;
  logic [CNT_W-1:0]    cnt;
  logic                zero_flag;
  logic                zero_evt;

  wdog_regs #(.RELOAD_W(RELOAD_W)) u_regs (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .zero_flag(zero_flag),
    .mode(mode), .pre_sel(pre_sel), .reload(reload),
    .restart_hit(restart_hit), .rsp_rdata(rsp_rdata)
  );

  wdog_timer #(.RELOAD_W(RELOAD_W), .LOW_W(LOW_W)) u_timer (
    .clk(clk), .rst(rst),
    .en(mode.en), .pre_sel(pre_sel), .reload(reload),
    .restart(restart_hit),
    .cnt(cnt), .zero_flag(zero_flag), .zero_evt(zero_evt)
  );

  wdog_out u_out (
    .clk(clk), .rst(rst),
    .zero_flag(zero_flag), .zero_evt(zero_evt),
    .rst_en(mode.rst_en), .irq_en(mode.irq_en), .len(mode.len),
    .wdt_rst_o(wdt_rst_o), .wdt_irq_o(wdt_irq_o)
  );

endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_write,
  input logic [3:0]       req_addr,
  input logic [31:0]      req_wdata,
  input logic             en,
  input logic             rst_en,
  input logic             irq_en,
  input logic             restart_hit,
  input logic [CNT_W-1:0] cnt,
  input logic             zero_flag,
  input logic             wdt_rst_o,
  input logic             wdt_irq_o
);

  logic [5:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst) hi_run <= '0;
    else if (wdt_rst_o) hi_run <= (hi_run == 6'd63) ? hi_run : hi_run + 6'd1;
    else hi_run <= '0;
  end

  p_mode_key_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr == 4'h0 && req_wdata[23:12] != 12'hABC)
      |=> ($stable(en) && $stable(rst_en) && $stable(irq_en)));

  p_restart_clears_r5: assert property (@(posedge clk) disable iff (rst)
    restart_hit |=> !zero_flag);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!en && !restart_hit) |=> $stable(cnt));

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (zero_flag && !restart_hit) |=> zero_flag);

  p_pulse_max_r8: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_o |-> (hi_run < 6'd16));

  p_pulse_gated_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(wdt_rst_o) |-> $past(rst_en));

  p_irq_source_r9: assert property (@(posedge clk) disable iff (rst)
    wdt_irq_o |-> $past(zero_flag && irq_en));

endmodule

bind wdog_keyed wdog_keyed_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst),
  .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata),
  .en(mode.en), .rst_en(mode.rst_en), .irq_en(mode.irq_en),
  .restart_hit(restart_hit), .cnt(cnt), .zero_flag(zero_flag),
  .wdt_rst_o(wdt_rst_o), .wdt_irq_o(wdt_irq_o)
);

// File: tb/tb_wdog_keyed.sv
`timescale 1ns/1ps
module tb_wdog_keyed;

  localparam int LOW_W = 3;
  localparam int ONES  = (1 << LOW_W) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        wdt_rst_o, wdt_irq_o;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  wdog_keyed #(.LOW_W(LOW_W)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .wdt_rst_o(wdt_rst_o), .wdt_irq_o(wdt_irq_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // called at a negedge; returns the edge number that accepts the write
  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d, output int acc);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    acc = cyc + 1;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    int acc;
    bus_wr(a, d, acc);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    d = rsp_rdata;
    req_valid = 1'b0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic quiesce();
    wr(4'h0, 32'h00AB_C000);
    wr(4'h8, 32'h0000_1999);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 rst_o", 32'(wdt_rst_o), 0);
    chk("R1 irq_o", 32'(wdt_irq_o), 0);
    rd(4'h0, d); chk("R1 mode", d, 32'h0);
    rd(4'h4, d); chk("R1 cctl", d, 32'h0000_3FFC);
    rd(4'hC, d); chk("R1 status", d, 32'h0);
  endtask

  task automatic t_keys();
    logic [31:0] d;
    wr(4'h0, 32'h00AB_B005); rd(4'h0, d); chk("R2 bad key ignored", d, 32'h0);
    wr(4'h0, 32'h00AB_C034); rd(4'h0, d); chk("R2 keyed write, key reads 0", d, 32'h34);
    wr(4'h4, 32'h0091_0005); rd(4'h4, d); chk("R3 bad key ignored", d, 32'h0000_3FFC);
    wr(4'h4, 32'h00AB_C005); rd(4'h4, d); chk("R3 mode key on cctl ignored", d, 32'h0000_3FFC);
    wr(4'h4, 32'h0092_0009); rd(4'h4, d); chk("R3 keyed write, key reads 0", d, 32'h9);
    wr(4'h0, 32'h00AB_C000);
  endtask

  // timeout with given cctl word; expected period T
  task automatic run_timeout(input string req, input logic [31:0] cw, input int t);
    int t0;
    logic [31:0] d;
    wr(4'h4, cw);
    wr(4'h0, 32'h00AB_C005);
    bus_wr(4'h8, 32'h0000_1999, t0);
    wait_until(t0 + t);
    chk({req, " irq low before period"}, 32'(wdt_irq_o), 0);
    @(negedge clk);
    chk({req, " irq high after period"}, 32'(wdt_irq_o), 1);
  endtask

  task automatic t_timeout();
    logic [31:0] d;
    run_timeout("R4 div8 reload0", 32'h0092_0000, ONES * 8);
    run_timeout("R4 div8 reload1", 32'h0092_0004, (8 + ONES) * 8);
    run_timeout("R4 div64 reload0", 32'h0092_0001, ONES * 64);
    repeat (50) @(negedge clk);
    rd(4'hC, d); chk("R7 flag sticky", d, 32'h1);
    chk("R9 irq level held", 32'(wdt_irq_o), 1);
    wr(4'h8, 32'h0000_1998);
    @(negedge clk);
    rd(4'hC, d); chk("R5 wrong restart ignored", d, 32'h1);
    wr(4'h8, 32'h0000_1999);
    rd(4'hC, d); chk("R5 restart clears flag", d, 32'h0);
    chk("R9 irq falls after restart", 32'(wdt_irq_o), 0);
    quiesce();
  endtask

  task automatic pulse_run(input logic [1:0] code, input int exp_len);
    int t0, n;
    wr(4'h4, 32'h0092_0000);
    wr(4'h0, 32'h00AB_C003 | (32'(code) << 4));
    bus_wr(4'h8, 32'h0000_1999, t0);
    wait_until(t0 + ONES * 8);
    chk("R8 no pulse before timeout", 32'(wdt_rst_o), 0);
    @(negedge clk);
    n = 0;
    while (wdt_rst_o && n < 40) begin n++; @(negedge clk); end
    chk("R8 pulse length", 32'(n), 32'(exp_len));
    repeat (40) @(negedge clk);
    chk("R8 single pulse", 32'(wdt_rst_o), 0);
    chk("R9 irq off when disabled", 32'(wdt_irq_o), 0);
    quiesce();
  endtask

  task automatic t_pulse();
    pulse_run(2'b00, 2);
    pulse_run(2'b10, 8);
    pulse_run(2'b11, 16);
  endtask

  task automatic t_hold();
    int t0, d_e, e_e, rem;
    logic [31:0] d;
    wr(4'h4, 32'h0092_0004);
    wr(4'h0, 32'h00AB_C005);
    bus_wr(4'h8, 32'h0000_1999, t0);
    repeat (37) @(negedge clk);
    bus_wr(4'h0, 32'h00AB_C004, d_e);
    repeat (300) @(negedge clk);
    chk("R6 no timeout while disabled", 32'(wdt_irq_o), 0);
    rd(4'hC, d); chk("R6 status clear while held", d, 0);
    bus_wr(4'h0, 32'h00AB_C005, e_e);
    rem = (8 + ONES) * 8 - (d_e - t0);
    wait_until(e_e + rem);
    chk("R6 resumes, irq low before remainder", 32'(wdt_irq_o), 0);
    @(negedge clk);
    chk("R6 fires after remainder", 32'(wdt_irq_o), 1);
    quiesce();
  endtask

  task automatic t_race();
    int t0, t1, tt;
    logic [31:0] d;
    tt = ONES * 8;
    wr(4'h4, 32'h0092_0000);
    wr(4'h0, 32'h00AB_C005);
    bus_wr(4'h8, 32'h0000_1999, t0);
    wait_until(t0 + tt - 1);
    bus_wr(4'h8, 32'h0000_1999, t1);
    chk("R10 restart lands on terminal edge", 32'(t1), 32'(t0 + tt));
    chk("R10 no irq after collision", 32'(wdt_irq_o), 0);
    rd(4'hC, d); chk("R10 status clear after collision", d, 0);
    wait_until(t1 + tt);
    chk("R10 irq low before new period", 32'(wdt_irq_o), 0);
    @(negedge clk);
    chk("R10 fires one period after collision", 32'(wdt_irq_o), 1);
    quiesce();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_keys();
    t_timeout();
    t_pulse();
    t_hold();
    t_race();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    while (cyc < 150000) @(negedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule